// File: doc/BRIEF.md
# DMA Channel Start Controller

This block is the register-write front end of a ten-channel DMA engine. A single write port reaches three kinds of target: a channel's control word, a channel's transfer-count word, and the global control word. Each write to a control word decides what happens to that channel. The channel can be launched straight away. It can be parked in a pending mask when the engine is globally disabled. On a 32-bit write, the upper (tag) half of the stored word can be kept. The block drives one launch pulse per channel and an error pulse. It moves no data and interprets no tags.

Start requests parked while the engine is disabled are released when the global enable turns on. They go out one per cycle, lowest channel number first. A combinational read port returns any channel's stored control and count words, so that software-visible state can be observed.

Top module: `chan_launch_front`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every control word, every count word, the pending mask, the global enable, every launch pulse and the error pulse.
- R2: A 16-bit control write (wr_wide=0) replaces bits 15:0 of the addressed control word. Bits 31:16 keep their old value.
- R3: A 32-bit control write whose mode field (bits 3:2) equals 01 and whose bits 31:16 are zero keeps the stored bits 31:16 and replaces bits 15:0. Any other 32-bit control write stores all 32 bits.
- R4: On any control write, if bits 31:16 of that channel's count word are non-zero, the whole count word becomes zero. Otherwise the count word is unchanged.
- R5: A control write with bit 8 (start) set while the global enable (bit 0 of the global word) is 1 produces a launch pulse on that channel's bit only. The pulse comes in the cycle after the write and lasts one cycle.
- R6: A control write with bit 8 set while the global enable is 0 sets that channel's bit in the pending mask and produces no launch.
- R7: When a global write turns the enable from 0 to 1, the pending channels are launched from lowest index to highest, one per cycle. The first goes out in the second cycle after the write, and each pending bit clears as its launch is issued. Channel index i maps to pending bit i and launch bit i.
- R8: A control write with bit 8 set, to a channel whose stored bit 8 is already 1 while the enable is 1, raises busy_err for one cycle. The write is still stored and still launches.
- R9: A control write to a channel index of 10 or above changes no state and produces no launch, no pending bit and no error. A read of such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | Target: 0 control word, 1 count word, 2 global word, 3 none |
| wr_chan | input | 4 | Channel index for control or count writes |
| wr_wide | input | 1 | 1 for a 32-bit write, 0 for a 16-bit write |
| wr_data | input | 32 | Write data |
| rd_chan | input | 4 | Channel index for readback |
| rd_ctrl | output | 32 | Stored control word of rd_chan |
| rd_count | output | 32 | Stored count word of rd_chan |
| launch | output | 10 | One-cycle launch pulses, bit i for channel i |
| busy_err | output | 1 | One-cycle pulse on a start written to a running channel |
| pend_mask | output | 10 | Deferred start requests |
| glob_en | output | 1 | Current global enable |

## Verification
Most state errors show at the ports within one cycle. A wrong tag-keep or half-write decision shows on rd_ctrl in the cycle after the write, and a missed count clear shows on rd_count at the same point. A corrupted pending mask or a broken replay order shows on pend_mask and on launch, in the cycles that follow the enable edge. There a skipped, doubled or reordered pulse can be compared one cycle at a time against the expected lowest-first sequence. A stale running bit shows up only at the next start write to that channel, as a missing or spurious busy_err.

// File: rtl/chl_pkg.sv
// Shared constants for the channel start controller.
// Assumes a 32-bit control word with the start flag and the mode field at
// the positions used by neighbouring channel logic.
package chl_pkg;
    localparam logic [1:0] WK_CTRL   = 2'd0;
    localparam logic [1:0] WK_COUNT  = 2'd1;
    localparam logic [1:0] WK_GLOBAL = 2'd2;

    localparam int         START_BIT  = 8;
    localparam int         MODE_LSB   = 2;
    localparam logic [1:0] MODE_CHAIN = 2'b01;
    localparam int         ENABLE_BIT = 0;
endpackage

// File: rtl/chl_chan_regs.sv
// Per-channel control and count storage with the tag-keeping write rule.
// Assumes at most one write per cycle; out-of-range channel indices hit no
// register and read back as zero.
module chl_chan_regs
    import chl_pkg::*;
#(
    parameter int NCH = 10,
    parameter int DW  = 32,
    parameter int CW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_kind,
    input  logic [CW-1:0] wr_chan,
    input  logic          wr_wide,
    input  logic [DW-1:0] wr_data,
    input  logic [CW-1:0] rd_chan,
    output logic [DW-1:0] rd_ctrl,
    output logic [DW-1:0] rd_count,
    output logic [NCH-1:0] run_vec
);
    localparam int HW = DW / 2;

    logic [DW-1:0] ctrl_arr [NCH];
    logic [DW-1:0] cnt_arr  [NCH];

    logic wr_tag_zero;
    logic wr_is_chain;
    assign wr_tag_zero = (wr_data[DW-1:HW] == '0);
    assign wr_is_chain = (wr_data[MODE_LSB+1:MODE_LSB] == MODE_CHAIN);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic          hit_ctrl;
        logic          hit_cnt;
        logic [DW-1:0] ctrl_q;
        logic [DW-1:0] cnt_q;

        assign hit_ctrl = wr_en && (wr_kind == WK_CTRL)  && (wr_chan == CW'(g));
        assign hit_cnt  = wr_en && (wr_kind == WK_COUNT) && (wr_chan == CW'(g));

        // Control word: half write, tag-keeping chain write or full write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q <= '0;
            end else if (hit_ctrl) begin
                if (!wr_wide) begin
                    ctrl_q[HW-1:0] <= wr_data[HW-1:0];
                end else if (wr_is_chain && wr_tag_zero) begin
                    ctrl_q[HW-1:0] <= wr_data[HW-1:0];
                end else begin
                    ctrl_q <= wr_data;
                end
            end
        end

        // Count word: direct write, or cleared when its upper half is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (hit_ctrl) begin
                if (cnt_q[DW-1:HW] != '0) begin
                    cnt_q <= '0;
                end
            end else if (hit_cnt) begin
                cnt_q <= wr_data;
            end
        end

        assign ctrl_arr[g] = ctrl_q;
        assign cnt_arr[g]  = cnt_q;
        assign run_vec[g]  = ctrl_q[START_BIT];

        AST_HALF_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_ctrl && !wr_wide) |=> (ctrl_q[DW-1:HW] == $past(ctrl_q[DW-1:HW]))); // R2
        AST_CHAIN_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_ctrl && wr_wide && wr_is_chain && wr_tag_zero)
            |=> (ctrl_q[DW-1:HW] == $past(ctrl_q[DW-1:HW]))); // R3
        AST_COUNT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            hit_ctrl |=> (cnt_q[DW-1:HW] == '0)); // R4
    end

    // Readback mux for the selected channel.
    always_comb begin
        rd_ctrl  = '0;
        rd_count = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_chan == CW'(i)) begin
                rd_ctrl  = ctrl_arr[i];
                rd_count = cnt_arr[i];
            end
        end
    end
endmodule

// File: rtl/chl_start_decode.sv
// Combinational decode of a control write into immediate launch, deferral
// and busy-error requests. Assumes run_vec reflects stored start flags
// before the current write lands.
module chl_start_decode
    import chl_pkg::*;
#(
    parameter int NCH = 10,
    parameter int CW  = 4
) (
    input  logic           wr_en,
    input  logic [1:0]     wr_kind,
    input  logic [CW-1:0]  wr_chan,
    input  logic           wr_start,
    input  logic           en,
    input  logic [NCH-1:0] run_vec,
    output logic [NCH-1:0] imm_vec,
    output logic [NCH-1:0] set_vec,
    output logic           err_now,
    output logic           glob_wr
);
    logic [NCH-1:0] hit_vec;

    for (genvar g = 0; g < NCH; g++) begin : g_hit
        assign hit_vec[g] = wr_en && (wr_kind == WK_CTRL) && (wr_chan == CW'(g));
    end

    // Split a start request by the current global enable.
    always_comb begin
        imm_vec = hit_vec & {NCH{wr_start &&  en}};
        set_vec = hit_vec & {NCH{wr_start && !en}};
        err_now = wr_start && en && ((hit_vec & run_vec) != '0);
        glob_wr = wr_en && (wr_kind == WK_GLOBAL);
    end
endmodule

// File: rtl/chl_pend_replay.sv
// Global enable, pending mask and lowest-first replay arbiter.
// Assumes set requests arrive only while disabled; replay is armed by a
// 0-to-1 enable write and stops when the mask drains or enable drops.
module chl_pend_replay #(
    parameter int NCH = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_vec,
    input  logic           glob_wr,
    input  logic           glob_val,
    output logic           en_q,
    output logic [NCH-1:0] pend_q,
    output logic [NCH-1:0] grant
);
    logic replay_q;

    // Pick the lowest pending channel while replay is armed and enabled.
    always_comb begin
        grant = '0;
        if (replay_q && en_q) begin
            for (int i = NCH - 1; i >= 0; i--) begin
                if (pend_q[i]) begin
                    grant = NCH'(1) << i;
                end
            end
        end
    end

    // Global enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (glob_wr) en_q <= glob_val;
    end

    // Replay arm flag: set on the enable rising edge, cleared when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            replay_q <= 1'b0;
        end else if (glob_wr && glob_val && !en_q) begin
            replay_q <= 1'b1;
        end else if (replay_q && (!en_q || ((pend_q & ~grant) == '0))) begin
            replay_q <= 1'b0;
        end
    end

    // Pending mask: retire granted bits, capture deferred requests.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~grant) | set_vec;
    end

    AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec))); // R6
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7
    AST_GRANT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> ((pend_q & $past(grant)) == '0)); // R7
endmodule

// File: rtl/chan_launch_front.sv
// Top of the channel start controller: register storage, start decode,
// deferral/replay and registered launch and error pulses.
// Assumes one write per cycle on a single port.
module chan_launch_front #(
    parameter  int NCH = 10,
    parameter  int DW  = 32,
    localparam int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_kind,
    input  logic [CW-1:0]  wr_chan,
    input  logic           wr_wide,
    input  logic [DW-1:0]  wr_data,
    input  logic [CW-1:0]  rd_chan,
    output logic [DW-1:0]  rd_ctrl,
    output logic [DW-1:0]  rd_count,
    output logic [NCH-1:0] launch,
    output logic           busy_err,
    output logic [NCH-1:0] pend_mask,
    output logic           glob_en
);
    import chl_pkg::*;

    logic [NCH-1:0] run_vec;
    logic [NCH-1:0] imm_vec;
    logic [NCH-1:0] set_vec;
    logic [NCH-1:0] grant;
    logic           err_now;
    logic           glob_wr;
    logic [NCH-1:0] launch_q;
    logic           err_q;

    chl_chan_regs #(.NCH(NCH), .DW(DW), .CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_kind  (wr_kind),
        .wr_chan  (wr_chan),
        .wr_wide  (wr_wide),
        .wr_data  (wr_data),
        .rd_chan  (rd_chan),
        .rd_ctrl  (rd_ctrl),
        .rd_count (rd_count),
        .run_vec  (run_vec)
    );

    chl_start_decode #(.NCH(NCH), .CW(CW)) u_dec (
        .wr_en    (wr_en),
        .wr_kind  (wr_kind),
        .wr_chan  (wr_chan),
        .wr_start (wr_data[START_BIT]),
        .en       (glob_en),
        .run_vec  (run_vec),
        .imm_vec  (imm_vec),
        .set_vec  (set_vec),
        .err_now  (err_now),
        .glob_wr  (glob_wr)
    );

    chl_pend_replay #(.NCH(NCH)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .glob_wr  (glob_wr),
        .glob_val (wr_data[ENABLE_BIT]),
        .en_q     (glob_en),
        .pend_q   (pend_mask),
        .grant    (grant)
    );

    // Registered launch and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch_q <= '0;
            err_q    <= 1'b0;
        end else begin
            launch_q <= imm_vec | grant;
            err_q    <= err_now;
        end
    end

    assign launch   = launch_q;
    assign busy_err = err_q;

    AST_LAUNCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (launch != '0) |-> $past(glob_en)); // R5
    AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err |-> glob_en); // R8
    AST_ERR_WITH_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err |-> (launch != '0)); // R8
endmodule

// File: tb/sim_chan_launch_front.sv
module sim_chan_launch_front;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_kind;
    logic [3:0]  wr_chan;
    logic        wr_wide;
    logic [31:0] wr_data;
    logic [3:0]  rd_chan;
    logic [31:0] rd_ctrl;
    logic [31:0] rd_count;
    logic [9:0]  launch;
    logic        busy_err;
    logic [9:0]  pend_mask;
    logic        glob_en;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    localparam logic [1:0] K_CTRL = 2'd0, K_CNT = 2'd1, K_GLOB = 2'd2;

    always #4 clk = ~clk;

    chan_launch_front u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_chan(wr_chan), .wr_wide(wr_wide), .wr_data(wr_data),
        .rd_chan(rd_chan), .rd_ctrl(rd_ctrl), .rd_count(rd_count),
        .launch(launch), .busy_err(busy_err), .pend_mask(pend_mask),
        .glob_en(glob_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input logic [3:0] ch, input logic w, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_chan = ch; wr_wide = w; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_kind = 2'd3;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic read_ctrl(input logic [3:0] ch, input string req, input logic [31:0] exp);
        rd_chan = ch;
        #1;
        check(req, rd_ctrl, exp);
    endtask

    task automatic read_cnt(input logic [3:0] ch, input string req, input logic [31:0] exp);
        rd_chan = ch;
        #1;
        check(req, rd_count, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 launch", 32'(launch), 32'h0);
        check("R1 pend", 32'(pend_mask), 32'h0);
        check("R1 enable", 32'(glob_en), 32'h0);
        check("R1 err", 32'(busy_err), 32'h0);
        read_ctrl(4'd3, "R1 ctrl", 32'h0);
    endtask

    task automatic t_immediate();
        wr(K_GLOB, 4'd0, 1'b1, 32'h1);
        check("R5 enable on, no launch", 32'(launch), 32'h0);
        wr(K_CTRL, 4'd2, 1'b1, 32'h0000_0100);
        check("R5 launch ch2", 32'(launch), 32'h004);
        check("R5 no err", 32'(busy_err), 32'h0);
        step();
        check("R5 pulse ends", 32'(launch), 32'h0);
    endtask

    task automatic t_busy();
        wr(K_CTRL, 4'd2, 1'b1, 32'h0000_0100);
        check("R8 err pulse", 32'(busy_err), 32'h1);
        check("R8 still launches", 32'(launch), 32'h004);
        read_ctrl(4'd2, "R8 stored", 32'h0000_0100);
        wr(K_CTRL, 4'd2, 1'b1, 32'h0);
        check("R8 stop no err", 32'(busy_err), 32'h0);
        check("R8 stop no launch", 32'(launch), 32'h0);
    endtask

    task automatic t_half();
        wr(K_CTRL, 4'd5, 1'b1, 32'hABCD_0010);
        read_ctrl(4'd5, "R3 full store", 32'hABCD_0010);
        wr(K_CTRL, 4'd5, 1'b0, 32'h1234_0041);
        read_ctrl(4'd5, "R2 low half only", 32'hABCD_0041);
        check("R2 no launch", 32'(launch), 32'h0);
    endtask

    task automatic t_chain();
        wr(K_CTRL, 4'd6, 1'b1, 32'h5A5A_0000);
        wr(K_CTRL, 4'd6, 1'b1, 32'h0000_0004);
        read_ctrl(4'd6, "R3 chain keeps tag", 32'h5A5A_0004);
        wr(K_CTRL, 4'd6, 1'b1, 32'h7777_0004);
        read_ctrl(4'd6, "R3 chain nonzero tag", 32'h7777_0004);
        wr(K_CTRL, 4'd6, 1'b1, 32'h0000_0008);
        read_ctrl(4'd6, "R3 other mode full", 32'h0000_0008);
    endtask

    task automatic t_count();
        wr(K_CNT, 4'd3, 1'b1, 32'h0001_0005);
        read_cnt(4'd3, "R4 count written", 32'h0001_0005);
        wr(K_CTRL, 4'd3, 1'b1, 32'h0);
        read_cnt(4'd3, "R4 count cleared", 32'h0);
        wr(K_CNT, 4'd3, 1'b1, 32'h0000_0009);
        wr(K_CTRL, 4'd3, 1'b1, 32'h0);
        read_cnt(4'd3, "R4 count kept", 32'h0000_0009);
    endtask

    task automatic t_range();
        wr(K_CTRL, 4'd12, 1'b1, 32'h0000_0100);
        check("R9 no launch", 32'(launch), 32'h0);
        check("R9 no err", 32'(busy_err), 32'h0);
        check("R9 no pend", 32'(pend_mask), 32'h0);
        read_ctrl(4'd12, "R9 read zero", 32'h0);
    endtask

    task automatic t_defer();
        wr(K_GLOB, 4'd0, 1'b1, 32'h0);
        wr(K_CTRL, 4'd7, 1'b1, 32'h0000_0100);
        check("R6 no launch", 32'(launch), 32'h0);
        check("R6 pend ch7", 32'(pend_mask), 32'h080);
        wr(K_CTRL, 4'd1, 1'b0, 32'hFFFF_0100);
        wr(K_CTRL, 4'd4, 1'b1, 32'h0000_0100);
        check("R6 pend mask", 32'(pend_mask), 32'h092);
        wr(K_GLOB, 4'd0, 1'b1, 32'h1);
        check("R7 edge cycle idle", 32'(launch), 32'h0);
        step();
        check("R7 first ch1", 32'(launch), 32'h002);
        check("R7 pend after 1", 32'(pend_mask), 32'h090);
        step();
        check("R7 second ch4", 32'(launch), 32'h010);
        check("R7 pend after 2", 32'(pend_mask), 32'h080);
        step();
        check("R7 third ch7", 32'(launch), 32'h080);
        check("R7 drained", 32'(pend_mask), 32'h0);
        step();
        check("R7 done", 32'(launch), 32'h0);
    endtask

    task automatic t_reset_pend();
        wr(K_GLOB, 4'd0, 1'b1, 32'h0);
        wr(K_CTRL, 4'd0, 1'b1, 32'h0000_0100);
        check("R6 pend ch0", 32'(pend_mask), 32'h001);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 pend cleared", 32'(pend_mask), 32'h0);
        read_ctrl(4'd0, "R1 ctrl cleared", 32'h0);
    endtask

    initial begin
        wr_en = 1'b0; wr_kind = 2'd3; wr_chan = '0; wr_wide = 1'b0;
        wr_data = '0; rd_chan = '0;
        t_reset();
        t_immediate();
        t_busy();
        t_half();
        t_chain();
        t_count();
        t_range();
        t_defer();
        t_reset_pend();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule